// File: doc/BRIEF.md
# Send DMA Engine State Controller

This block sequences a send DMA engine through its life cycle: powered down, waiting for the hardware to start, idle, running, and an ordered recovery chain of halt, hardware clean-up and software clean-up. Callers raise single-cycle event pulses on a one-hot event vector. The controller answers with its registered state, a four-bit engine control word chosen by the state it enters, and one-cycle command pulses. The pulses ask the surrounding logic to start a software clean-up, start a hardware clean-up, disarm and restart the engine, or drop the engine's reference.

A sticky run request, held inside the block, records whether running has been asked for. When startup completes, the request decides between idle and running. A go-down does not clear the request, so the engine comes back running after a restart. The two halt causes end differently. One drops straight into software clean-up. The other waits for the engine to drain, then goes through hardware clean-up first. The code of the last accepted event stays visible for debug.

Top module: `txdma_state_ctl`

## Requirements
- R1: After synchronous reset the state is down (code 0), the control word is halt only (4'b0100), no command pulse is high, the last-event output is 4'hF, and the run request is clear.
- R2: An event vector with no bit set, or with more than one bit set, changes nothing: state, control word and last event hold, and no pulse is issued.
- R3: In down (0), go-start (bit 1) moves to startup-wait (1). Go-running (bit 3) moves to startup-wait and sets the run request. Sw-cleaned (bit 4) keeps the state and pulses release (cmd bit 3).
- R4: In startup-wait, hw-started (bit 2) moves to running (6) if the run request is set and to idle (2) if not. Go-running and go-idle (bit 7) in this state only set or clear the request.
- R5: In idle, go-running moves to running and sets the run request.
- R6: Go-down (bit 0) enters down from every other state. From startup-wait or idle it pulses release. From running, halt-wait (5) or hw-cleanup-wait (4) it pulses software clean-up (cmd bit 0). From sw-cleanup-wait (3) it issues no pulse.
- R7: In running, hw-halted (bit 6) or error A (bit 8) moves to sw-cleanup-wait and pulses software clean-up.
- R8: In running, go-idle moves to halt-wait and clears the run request. Error B (bit 9) moves to halt-wait and leaves the request unchanged.
- R9: The recovery chain runs in this order. In halt-wait, hw-halted moves to hw-cleanup-wait and pulses hardware clean-up (cmd bit 1). In hw-cleanup-wait, hw-cleaned (bit 5) moves to sw-cleanup-wait and pulses software clean-up. In sw-cleanup-wait, sw-cleaned moves to startup-wait and pulses engine start-up (cmd bit 2).
- R10: The timer tick (bit 10), and any single event with no entry above for the current state, leaves the state unchanged and issues no pulse.
- R11: The control word (bit 0 enable, bit 1 interrupt enable, bit 2 halt, bit 3 drain) is 4'b0011 in running, 4'b1001 in halt-wait, 4'b0100 in down and both clean-up waits, and 4'b0000 in startup-wait and idle. It changes on the same clock edge as the state.
- R12: Every state change and pulse appears on the clock edge that samples the event. A pulse lasts exactly one cycle. The last-event output takes the bit index of every single-bit event, including ignored ones.
- R13: The run request survives a go-down, so down, go-start, hw-started ends in running if running was requested before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 11 | One-hot event pulses, bit index = event code |
| state_o | output | 3 | Current state code |
| ctrl_o | output | 4 | Engine control word |
| cmd_o | output | 4 | One-cycle command pulses |
| last_ev_o | output | 4 | Code of the last single-bit event, 4'hF after reset |

## Verification
The bench drives every defined transition, and also ignored events placed in states where a neighbouring state would act on them. This separates a correct per-state table from one that applies an event everywhere. Runs through startup repeat the same hw-started event under different run-request histories: fresh reset, go-running, error B, go-idle, and a go-down in between. Only the sticky flag separates these outcomes. Multi-hot and empty vectors are sent to show they are rejected as a whole. The idle cycle after each event confirms that each pulse ends after one cycle.

// File: rtl/txdma_seq_pkg.sv
`timescale 1ns/1ps
// txdma_seq_pkg: shared encodings for the send DMA state controller.
// Assumes event codes equal their bit index in the event vector.
package txdma_seq_pkg;
    localparam int EV_N   = 11;
    localparam int EV_W   = $clog2(EV_N + 1);
    localparam int ST_W   = 3;
    localparam int CTRL_W = 4;
    localparam int CMD_W  = 4;

    typedef enum logic [ST_W-1:0] {
        ST_DOWN    = 3'd0,
        ST_STARTUP = 3'd1,
        ST_IDLE    = 3'd2,
        ST_SWCLN   = 3'd3,
        ST_HWCLN   = 3'd4,
        ST_HALTW   = 3'd5,
        ST_RUN     = 3'd6
    } seq_state_t;

    localparam logic [EV_W-1:0] EV_GO_DOWN    = 4'd0;
    localparam logic [EV_W-1:0] EV_GO_START   = 4'd1;
    localparam logic [EV_W-1:0] EV_HW_STARTED = 4'd2;
    localparam logic [EV_W-1:0] EV_GO_RUNNING = 4'd3;
    localparam logic [EV_W-1:0] EV_SW_CLEANED = 4'd4;
    localparam logic [EV_W-1:0] EV_HW_CLEANED = 4'd5;
    localparam logic [EV_W-1:0] EV_HW_HALTED  = 4'd6;
    localparam logic [EV_W-1:0] EV_GO_IDLE    = 4'd7;
    localparam logic [EV_W-1:0] EV_ERR_A      = 4'd8;
    localparam logic [EV_W-1:0] EV_ERR_B      = 4'd9;
    localparam logic [EV_W-1:0] EV_TICK       = 4'd10;
    localparam logic [EV_W-1:0] EV_NONE       = '1;

    localparam int CTL_EN    = 0;
    localparam int CTL_IEN   = 1;
    localparam int CTL_HALT  = 2;
    localparam int CTL_DRAIN = 3;

    localparam int CMD_SWCLN   = 0;
    localparam int CMD_HWCLN   = 1;
    localparam int CMD_HWSTART = 2;
    localparam int CMD_RELEASE = 3;

    // Control word that belongs to a state, applied on entry.
    function automatic logic [CTRL_W-1:0] ctrl_of(seq_state_t s);
        logic [CTRL_W-1:0] w;
        w = '0;
        unique case (s)
            ST_RUN: begin
                w[CTL_EN]  = 1'b1;
                w[CTL_IEN] = 1'b1;
            end
            ST_HALTW: begin
                w[CTL_EN]    = 1'b1;
                w[CTL_DRAIN] = 1'b1;
            end
            ST_DOWN, ST_SWCLN, ST_HWCLN: w[CTL_HALT] = 1'b1;
            default: w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/txdma_ev_decode.sv
`timescale 1ns/1ps
// txdma_ev_decode: checks that exactly one event bit is high and encodes it.
// Assumes nothing about the caller; zero or several bits yield ev_valid = 0.
module txdma_ev_decode
    import txdma_seq_pkg::*;
(
    input  logic [EV_N-1:0] ev_vec,
    output logic            ev_valid,
    output logic [EV_W-1:0] ev_idx
);
    logic [EV_W-1:0] idx_term [EV_N];

    // Each set bit contributes its own index; the others contribute zero.
    for (genvar g = 0; g < EV_N; g++) begin : g_term
        assign idx_term[g] = ev_vec[g] ? EV_W'(g) : '0;
    end

    // OR-reduce the terms; the result is meaningful only when one bit is set.
    always_comb begin
        ev_idx = '0;
        for (int i = 0; i < EV_N; i++) begin
            ev_idx = ev_idx | idx_term[i];
        end
    end

    // A valid event has exactly one bit set.
    assign ev_valid = $onehot(ev_vec);
endmodule

// File: rtl/txdma_seq_next.sv
`timescale 1ns/1ps
// txdma_seq_next: combinational transition table of the controller.
// Given the current state, a decoded event and the run request, it yields the
// next state, the command pulses to issue and the run-request updates.
// Assumes ev_idx is meaningful only when ev_valid is high.
module txdma_seq_next
    import txdma_seq_pkg::*;
(
    input  seq_state_t       cur,
    input  logic             ev_valid,
    input  logic [EV_W-1:0]  ev_idx,
    input  logic             run_req,
    output seq_state_t       nxt,
    output logic [CMD_W-1:0] cmd,
    output logic             req_set,
    output logic             req_clr
);
    // Per-state transitions and pulses; unlisted events keep the state.
    always_comb begin
        nxt = cur;
        cmd = '0;
        if (ev_valid) begin
            unique case (cur)
                ST_DOWN: begin
                    if (ev_idx == EV_GO_START || ev_idx == EV_GO_RUNNING) nxt = ST_STARTUP;
                    else if (ev_idx == EV_SW_CLEANED) cmd[CMD_RELEASE] = 1'b1;
                end
                ST_STARTUP: begin
                    if (ev_idx == EV_GO_DOWN) begin
                        nxt = ST_DOWN;
                        cmd[CMD_RELEASE] = 1'b1;
                    end else if (ev_idx == EV_HW_STARTED) begin
                        nxt = run_req ? ST_RUN : ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (ev_idx == EV_GO_DOWN) begin
                        nxt = ST_DOWN;
                        cmd[CMD_RELEASE] = 1'b1;
                    end else if (ev_idx == EV_GO_RUNNING) begin
                        nxt = ST_RUN;
                    end
                end
                ST_SWCLN: begin
                    if (ev_idx == EV_GO_DOWN) begin
                        nxt = ST_DOWN;
                    end else if (ev_idx == EV_SW_CLEANED) begin
                        nxt = ST_STARTUP;
                        cmd[CMD_HWSTART] = 1'b1;
                    end
                end
                ST_HWCLN: begin
                    if (ev_idx == EV_GO_DOWN) begin
                        nxt = ST_DOWN;
                        cmd[CMD_SWCLN] = 1'b1;
                    end else if (ev_idx == EV_HW_CLEANED) begin
                        nxt = ST_SWCLN;
                        cmd[CMD_SWCLN] = 1'b1;
                    end
                end
                ST_HALTW: begin
                    if (ev_idx == EV_GO_DOWN) begin
                        nxt = ST_DOWN;
                        cmd[CMD_SWCLN] = 1'b1;
                    end else if (ev_idx == EV_HW_HALTED) begin
                        nxt = ST_HWCLN;
                        cmd[CMD_HWCLN] = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (ev_idx == EV_GO_DOWN) begin
                        nxt = ST_DOWN;
                        cmd[CMD_SWCLN] = 1'b1;
                    end else if (ev_idx == EV_HW_HALTED || ev_idx == EV_ERR_A) begin
                        nxt = ST_SWCLN;
                        cmd[CMD_SWCLN] = 1'b1;
                    end else if (ev_idx == EV_GO_IDLE || ev_idx == EV_ERR_B) begin
                        nxt = ST_HALTW;
                    end
                end
                default: nxt = ST_DOWN;
            endcase
        end
    end

    // Go-running sets the request in every state; go-idle clears it outside down.
    always_comb begin
        req_set = ev_valid && (ev_idx == EV_GO_RUNNING);
        req_clr = ev_valid && (ev_idx == EV_GO_IDLE) && (cur != ST_DOWN);
    end
endmodule

// File: rtl/txdma_run_flag.sv
`timescale 1ns/1ps
// txdma_run_flag: sticky run-request bit. Set wins over clear (never both).
// Assumes synchronous active-low reset; the flag survives go-down events.
module txdma_run_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic req_set,
    input  logic req_clr,
    output logic run_req
);
    // Hold the request until an explicit set or clear arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_req <= 1'b0;
        else if (req_set) run_req <= 1'b1;
        else if (req_clr) run_req <= 1'b0;
    end

    assert_flag_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_set && !req_clr) |=> $stable(run_req));
endmodule

// File: rtl/txdma_state_ctl.sv
`timescale 1ns/1ps
// txdma_state_ctl: top of the send DMA engine state controller.
// Registers state, control word, command pulses and last event code.
// Assumes events arrive as one-cycle pulses; malformed vectors are dropped.
module txdma_state_ctl
    import txdma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EV_N-1:0]   ev_i,
    output logic [ST_W-1:0]   state_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [EV_W-1:0]   last_ev_o
);
    logic              ev_valid;
    logic [EV_W-1:0]   ev_idx;
    logic              run_req;
    logic              req_set;
    logic              req_clr;
    seq_state_t        state_q;
    seq_state_t        nxt;
    logic [CMD_W-1:0]  cmd_nxt;
    logic [CTRL_W-1:0] ctrl_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [EV_W-1:0]   last_q;

    txdma_ev_decode u_dec (
        .ev_vec   (ev_i),
        .ev_valid (ev_valid),
        .ev_idx   (ev_idx)
    );

    txdma_seq_next u_next (
        .cur      (state_q),
        .ev_valid (ev_valid),
        .ev_idx   (ev_idx),
        .run_req  (run_req),
        .nxt      (nxt),
        .cmd      (cmd_nxt),
        .req_set  (req_set),
        .req_clr  (req_clr)
    );

    txdma_run_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_set (req_set),
        .req_clr (req_clr),
        .run_req (run_req)
    );

    // State, control word of the entered state, pulses and debug event code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DOWN;
            ctrl_q  <= ctrl_of(ST_DOWN);
            cmd_q   <= '0;
            last_q  <= EV_NONE;
        end else begin
            state_q <= nxt;
            ctrl_q  <= ctrl_of(nxt);
            cmd_q   <= cmd_nxt;
            if (ev_valid) last_q <= ev_idx;
        end
    end

    assign state_o   = state_q;
    assign ctrl_o    = ctrl_q;
    assign cmd_o     = cmd_q;
    assign last_ev_o = last_q;

    assert_no_event_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> ($stable(state_q) && cmd_q == '0 && $stable(last_q)));

    assert_ctrl_tracks_state_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q == ctrl_of(state_q));

    assert_run_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) != ST_RUN) |->
        ($past(ev_idx) == EV_HW_STARTED || $past(ev_idx) == EV_GO_RUNNING));

    assert_release_in_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[CMD_RELEASE] |-> state_q == ST_DOWN);

    assert_hwstart_from_swcln_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q[CMD_HWSTART] |-> (state_q == ST_STARTUP && $past(state_q) == ST_SWCLN));

    assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_q));
endmodule

// File: tb/txdma_state_ctl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor compares.
module txdma_state_ctl_bench;
    localparam logic [2:0] S_DOWN = 3'd0, S_STUP = 3'd1, S_IDLE = 3'd2, S_SWC = 3'd3,
                           S_HWC = 3'd4, S_HLT = 3'd5, S_RUN = 3'd6;
    localparam int E_DOWN = 0, E_START = 1, E_STARTED = 2, E_RUNNING = 3, E_SWCLEANED = 4,
                   E_HWCLEANED = 5, E_HALTED = 6, E_IDLE = 7, E_ERRA = 8, E_ERRB = 9, E_TICK = 10;
    localparam logic [3:0] C_NONE = 4'b0000, C_SWC = 4'b0001, C_HWC = 4'b0010,
                           C_HWS = 4'b0100, C_REL = 4'b1000;

    typedef struct {
        logic [2:0] st;
        logic [3:0] ctl;
        logic [3:0] cmd;
        logic [3:0] lev;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ev = '0;
    logic [2:0]  state_o;
    logic [3:0]  ctrl_o, cmd_o, last_ev_o;

    exp_t       sb[$];
    int         checks = 0;
    int         fails = 0;
    logic [3:0] exp_last = 4'hF;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    txdma_state_ctl u_txdma_state_ctl (
        .clk(clk), .rst_n(rst_n), .ev_i(ev),
        .state_o(state_o), .ctrl_o(ctrl_o), .cmd_o(cmd_o), .last_ev_o(last_ev_o)
    );

    // Control word per state as stated in R11.
    function automatic logic [3:0] ctl_for(logic [2:0] s);
        case (s)
            S_RUN:                return 4'b0011;
            S_HLT:                return 4'b1001;
            S_DOWN, S_SWC, S_HWC: return 4'b0100;
            default:              return 4'b0000;
        endcase
    endfunction

    function automatic void cmp(exp_t e);
        checks++;
        if (state_o !== e.st || ctrl_o !== e.ctl || cmd_o !== e.cmd || last_ev_o !== e.lev) begin
            fails++;
            $display("FAIL %s: state/ctrl/cmd/last = %0d/%b/%b/%h expected %0d/%b/%b/%h",
                     e.tag, state_o, ctrl_o, cmd_o, last_ev_o, e.st, e.ctl, e.cmd, e.lev);
        end
    endfunction

    // Monitor: after each edge, pop one expected item if the driver queued one.
    always @(posedge clk) begin
        #1;
        if (sb.size() != 0) cmp(sb.pop_front());
    end

    // Driver: one event cycle, then one quiet cycle that must show no pulse.
    task automatic step_vec(input logic [10:0] v, input logic [2:0] st,
                            input logic [3:0] cmd, input string tag);
        exp_t e;
        @(negedge clk);
        ev = v;
        if ($countones(v) == 1)
            for (int i = 0; i < 11; i++) if (v[i]) exp_last = 4'(i);
        e = '{st, ctl_for(st), cmd, exp_last, tag};
        sb.push_back(e);
        @(negedge clk);
        ev = '0;
        e = '{st, ctl_for(st), C_NONE, exp_last, {tag, " quiet cycle R12"}};
        sb.push_back(e);
    endtask

    task automatic step(input int code, input logic [2:0] st,
                        input logic [3:0] cmd, input string tag);
        step_vec(11'(1) << code, st, cmd, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp('{S_DOWN, 4'b0100, C_NONE, 4'hF, "R1 reset state"});

        step(E_TICK,      S_DOWN, C_NONE, "R10 tick in down");
        step(E_IDLE,      S_DOWN, C_NONE, "R10 go-idle in down");
        step(E_SWCLEANED, S_DOWN, C_REL,  "R3 sw-cleaned in down");
        step_vec(11'b000_0000_1010, S_DOWN, C_NONE, "R2 multi-hot vector");
        step_vec(11'b0,             S_DOWN, C_NONE, "R2 empty vector");
        step(E_START,   S_STUP, C_NONE, "R3 go-start");
        step(E_STARTED, S_IDLE, C_NONE, "R1 R4 clear request lands in idle");
        step(E_ERRA,    S_IDLE, C_NONE, "R10 error A in idle");
        step(E_DOWN,    S_DOWN, C_REL,  "R6 go-down from idle");
        step(E_RUNNING, S_STUP, C_NONE, "R3 go-running from down");
        step(E_STARTED, S_RUN,  C_NONE, "R4 request set lands in running");
        step(E_RUNNING, S_RUN,  C_NONE, "R10 go-running in running");
        step(E_TICK,    S_RUN,  C_NONE, "R10 tick in running");
        step(E_ERRB,    S_HLT,  C_NONE, "R8 error B");
        step(E_HWCLEANED, S_HLT, C_NONE, "R10 hw-cleaned in halt-wait");
        step(E_HALTED,    S_HWC, C_HWC,  "R9 halt-wait to hw clean-up");
        step(E_HWCLEANED, S_SWC, C_SWC,  "R9 hw clean-up to sw clean-up");
        step(E_SWCLEANED, S_STUP, C_HWS, "R9 sw clean-up to startup");
        step(E_STARTED,   S_RUN, C_NONE, "R8 error B kept request");
        step(E_HALTED,    S_SWC, C_SWC,  "R7 hw-halted in running");
        step(E_SWCLEANED, S_STUP, C_HWS, "R9 restart");
        step(E_STARTED,   S_RUN, C_NONE, "R4 back to running");
        step(E_ERRA,      S_SWC, C_SWC,  "R7 error A in running");
        step(E_DOWN,      S_DOWN, C_NONE, "R6 go-down from sw clean-up");
        step(E_START,     S_STUP, C_NONE, "R13 restart after go-down");
        step(E_STARTED,   S_RUN, C_NONE, "R13 request survived go-down");
        step(E_DOWN,      S_DOWN, C_SWC, "R6 go-down from running");
        step(E_RUNNING,   S_STUP, C_NONE, "R3 go-running");
        step(E_IDLE,      S_STUP, C_NONE, "R4 go-idle in startup");
        step(E_STARTED,   S_IDLE, C_NONE, "R4 request cleared in startup");
        step(E_RUNNING,   S_RUN, C_NONE,  "R5 go-running in idle");
        step(E_IDLE,      S_HLT, C_NONE,  "R8 go-idle in running");
        step(E_DOWN,      S_DOWN, C_SWC,  "R6 go-down from halt-wait");
        step(E_START,     S_STUP, C_NONE, "R3 go-start");
        step(E_STARTED,   S_IDLE, C_NONE, "R8 go-idle cleared request");
        step(E_RUNNING,   S_RUN, C_NONE,  "R5 go-running in idle");
        step(E_IDLE,      S_HLT, C_NONE,  "R8 go-idle");
        step(E_HALTED,    S_HWC, C_HWC,   "R9 halt-wait to hw clean-up");
        step(E_DOWN,      S_DOWN, C_SWC,  "R6 go-down from hw clean-up");
        step(E_START,     S_STUP, C_NONE, "R3 go-start");
        step(E_DOWN,      S_DOWN, C_REL,  "R6 go-down from startup");
        step_vec(11'b110_0000_0000, S_DOWN, C_NONE, "R2 two-bit vector in down");
        step(E_TICK,      S_DOWN, C_NONE, "R11 R12 tick recorded");

        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule